// File: doc/BRIEF.md
# Main Control Decoder

This block turns a 32-bit instruction word into the control signals that steer a single-cycle datapath. The signals are:

- a branch request and a jump request;
- a register-file write enable and a data-memory write enable;
- a select for the register write-back source;
- a select for the destination register field;
- a select for the ALU's second operand;
- a two-bit ALU operation code.

Six instructions are recognised:

- a register-register add;
- an add-immediate;
- a word load;
- a word store;
- a branch-if-equal;
- an absolute jump.

Every other encoding decodes to a quiet no-op that writes nothing and redirects nothing.

The decoder is purely combinational. It reads only the major opcode in bits 31:26 and, for the register-register format (opcode 0x00), the function code in bits 5:0. The remaining fields pass to the datapath untouched and do not affect the decode.

Any output the instruction does not need is driven to 0. Because of this, each instruction has exactly one legal output pattern, and the whole output can be compared as a single word.

Top module: `main_ctrl_decoder`

## Requirements
- R1: Opcode 0x00 with function code 0x20 (add) gives branch=0, jump=0, reg write=1, mem write=0, write-back select=0 (ALU), destination select=1 (bits 15:11), ALU B select=0 (register) and ALU op=0 (add).
- R2: Opcode 0x08 (add immediate) gives reg write=1, write-back select=0, destination select=0 (bits 20:16) and ALU B select=1 (immediate). ALU op is 0, and branch, jump and mem write are 0.
- R3: Opcode 0x23 (load word) gives reg write=1, write-back select=1 (memory data), destination select=0, ALU B select=1 and ALU op=0, with branch, jump and mem write at 0.
- R4: Opcode 0x2B (store word) gives mem write=1, reg write=0, ALU B select=1 and ALU op=0, with branch and jump at 0. Register write and memory write are never both asserted for any input.
- R5: Opcode 0x04 (branch if equal) gives branch=1, ALU op=1 (subtract) and ALU B select=0, with jump, reg write and mem write at 0.
- R6: Opcode 0x02 (jump) gives jump=1 with reg write, mem write and branch at 0. Branch and jump are never both asserted.
- R7: Any opcode other than 0x00, 0x02, 0x04, 0x08, 0x23 and 0x2B drives every output to 0.
- R8: Opcode 0x00 with any function code other than 0x20 drives every output to 0.
- R9: Bits 25:6 never affect the outputs. For opcodes other than 0x00, bits 5:0 do not affect them either.
- R10: Outputs the instruction does not need are 0: write-back and destination select for store, branch and jump, and ALU B select and ALU op for jump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word to decode |
| br_o | output | 1 | Branch request (taken when operands compare equal) |
| jp_o | output | 1 | Absolute jump request |
| rwe_o | output | 1 | Register-file write enable |
| dmwe_o | output | 1 | Data-memory write enable |
| rwd_o | output | 1 | Write-back source: 0 ALU result, 1 memory data |
| rdst_o | output | 1 | Destination field: 0 bits 20:16, 1 bits 15:11 |
| alu_b_imm_o | output | 1 | ALU operand B: 0 register, 1 sign-extended immediate |
| alu_op_o | output | 2 | ALU operation: 0 add, 1 subtract |

## Verification
The hardest case to reach is the register-register format whose function code is not the add code. A decoder that forgets to qualify on the function code, or that tests it for every opcode, is wrong only there and in the random-looking low bits of other formats.

The stimulus therefore sweeps all 64 opcodes, each with several random payloads. It also pins opcode 0x00 against a list of near-miss function codes (0x00, 0x21, 0x22, 0x24, 0x28, 0x30).

Recognised opcodes are replayed with bits 5:0 set to 0x20 and 0x22 and with the middle field flooded with ones. This shows that only the documented fields steer the decode.

// File: rtl/ctrl_pkg.sv
package ctrl_pkg;

  localparam int INSTR_W = 32;
  localparam int OP_W    = 6;
  localparam int FUNCT_W = 6;
  localparam int ALUOP_W = 2;

  localparam logic [OP_W-1:0]    OPC_REG   = 6'h00;
  localparam logic [OP_W-1:0]    OPC_JUMP  = 6'h02;
  localparam logic [OP_W-1:0]    OPC_BEQ   = 6'h04;
  localparam logic [OP_W-1:0]    OPC_ADDI  = 6'h08;
  localparam logic [OP_W-1:0]    OPC_LOAD  = 6'h23;
  localparam logic [OP_W-1:0]    OPC_STORE = 6'h2B;
  localparam logic [FUNCT_W-1:0] FN_ADD    = 6'h20;

  localparam logic [ALUOP_W-1:0] ALU_ADD = ALUOP_W'(0);
  localparam logic [ALUOP_W-1:0] ALU_SUB = ALUOP_W'(1);

  typedef enum logic [2:0] {
    K_NOP    = 3'd0,
    K_ADD    = 3'd1,
    K_ADDI   = 3'd2,
    K_LOAD   = 3'd3,
    K_STORE  = 3'd4,
    K_BRANCH = 3'd5,
    K_JUMP   = 3'd6
  } insn_kind_e;

  localparam int NUM_KINDS = 7;

  typedef struct packed {
    logic               br;
    logic               jp;
    logic               rwe;
    logic               dmwe;
    logic               rwd;
    logic               rdst;
    logic               alu_b_imm;
    logic [ALUOP_W-1:0] alu_op;
  } ctrl_t;

  // Control pattern per instruction kind; unused selects stay at 0.
  function automatic ctrl_t ctrl_for(insn_kind_e k);
    ctrl_t c;
    c = '0;
    case (k)
      K_ADD: begin
        c.rwe  = 1'b1;
        c.rdst = 1'b1;
      end
      K_ADDI: begin
        c.rwe       = 1'b1;
        c.alu_b_imm = 1'b1;
      end
      K_LOAD: begin
        c.rwe       = 1'b1;
        c.rwd       = 1'b1;
        c.alu_b_imm = 1'b1;
      end
      K_STORE: begin
        c.dmwe      = 1'b1;
        c.alu_b_imm = 1'b1;
      end
      K_BRANCH: begin
        c.br     = 1'b1;
        c.alu_op = ALU_SUB;
      end
      K_JUMP: begin
        c.jp = 1'b1;
      end
      default: c = '0;
    endcase
    if (k != K_BRANCH && k != K_NOP && k != K_JUMP) c.alu_op = ALU_ADD;
    return c;
  endfunction

endpackage

// File: rtl/field_split.sv
module field_split
  import ctrl_pkg::*;
#(
  parameter int IW = INSTR_W,
  parameter int OW = OP_W,
  parameter int FW = FUNCT_W
) (
  input  logic [IW-1:0] instr_i,
  output logic [OW-1:0] op_o,
  output logic [FW-1:0] funct_o
);
  localparam int MID_HI = IW - OW - 1;

  logic unused_mid;

  assign op_o       = instr_i[IW-1 -: OW];
  assign funct_o    = instr_i[FW-1:0];
  assign unused_mid = ^instr_i[MID_HI:FW];
endmodule

// File: rtl/kind_classifier.sv
module kind_classifier
  import ctrl_pkg::*;
(
  input  logic [OP_W-1:0]      op_i,
  input  logic [FUNCT_W-1:0]   funct_i,
  output insn_kind_e           kind_o,
  output logic [NUM_KINDS-1:0] kind_hot_o
);
  always_comb begin
    case (op_i)
      OPC_REG:   kind_o = (funct_i == FN_ADD) ? K_ADD : K_NOP;
      OPC_ADDI:  kind_o = K_ADDI;
      OPC_LOAD:  kind_o = K_LOAD;
      OPC_STORE: kind_o = K_STORE;
      OPC_BEQ:   kind_o = K_BRANCH;
      OPC_JUMP:  kind_o = K_JUMP;
      default:   kind_o = K_NOP;
    endcase
  end

  for (genvar g = 0; g < NUM_KINDS; g++) begin : g_hot
    assign kind_hot_o[g] = (kind_o == insn_kind_e'(g));
  end

  always_comb begin
    assert_kind_onehot_R7: assert ($onehot(kind_hot_o))
      else $error("kind vector not one-hot");
    if (op_i != OPC_REG) begin
      assert_funct_ignored_R9: assert (kind_o != K_ADD)
        else $error("add decoded outside R-type");
    end
  end
endmodule

// File: rtl/ctrl_encoder.sv
module ctrl_encoder
  import ctrl_pkg::*;
(
  input  insn_kind_e kind_i,
  output ctrl_t      ctrl_o
);
  assign ctrl_o = ctrl_for(kind_i);

  always_comb begin
    assert_single_write_R4: assert (!(ctrl_o.rwe && ctrl_o.dmwe))
      else $error("both write enables high");
    assert_single_redirect_R6: assert (!(ctrl_o.br && ctrl_o.jp))
      else $error("branch and jump both high");
    if (kind_i == K_NOP) begin
      assert_nop_quiet_R7: assert (ctrl_o == '0)
        else $error("no-op drives controls");
    end
    if (ctrl_o.jp) begin
      assert_jump_quiet_R10: assert (!ctrl_o.rwe && !ctrl_o.dmwe && ctrl_o.alu_op == '0)
        else $error("jump drives unneeded controls");
    end
  end
endmodule

// File: rtl/main_ctrl_decoder.sv
module main_ctrl_decoder
  import ctrl_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output logic               br_o,
  output logic               jp_o,
  output logic               rwe_o,
  output logic               dmwe_o,
  output logic               rwd_o,
  output logic               rdst_o,
  output logic               alu_b_imm_o,
  output logic [ALUOP_W-1:0] alu_op_o
);
  logic [OP_W-1:0]      op_w;
  logic [FUNCT_W-1:0]   funct_w;
  insn_kind_e           kind_w;
  logic [NUM_KINDS-1:0] kind_hot_w;
  ctrl_t                ctrl_w;

  field_split #(.IW(INSTR_W), .OW(OP_W), .FW(FUNCT_W)) u_split (
    .instr_i (instr_i),
    .op_o    (op_w),
    .funct_o (funct_w)
  );

  kind_classifier u_class (
    .op_i       (op_w),
    .funct_i    (funct_w),
    .kind_o     (kind_w),
    .kind_hot_o (kind_hot_w)
  );

  ctrl_encoder u_enc (
    .kind_i (kind_w),
    .ctrl_o (ctrl_w)
  );

  assign br_o        = ctrl_w.br;
  assign jp_o        = ctrl_w.jp;
  assign rwe_o       = ctrl_w.rwe;
  assign dmwe_o      = ctrl_w.dmwe;
  assign rwd_o       = ctrl_w.rwd;
  assign rdst_o      = ctrl_w.rdst;
  assign alu_b_imm_o = ctrl_w.alu_b_imm;
  assign alu_op_o    = ctrl_w.alu_op;

  always_comb begin
    if (rdst_o) begin
      assert_rdst_rtype_R1: assert (op_w == OPC_REG && funct_w == FN_ADD)
        else $error("rd destination outside add");
    end
    if (rwd_o) begin
      assert_memdata_load_R3: assert (op_w == OPC_LOAD)
        else $error("memory write-back outside load");
    end
    if (br_o) begin
      assert_branch_sub_R5: assert (alu_op_o == ALU_SUB && op_w == OPC_BEQ)
        else $error("branch without subtract");
    end
    if (dmwe_o) begin
      assert_store_imm_R4: assert (alu_b_imm_o && op_w == OPC_STORE)
        else $error("store without immediate operand");
    end
  end
endmodule

// File: tb/main_ctrl_decoder_bench.sv
module main_ctrl_decoder_bench;
  logic        clk = 1'b0;
  logic [31:0] instr = 32'h0;
  logic        br, jp, rwe, dmwe, rwd, rdst, bimm;
  logic [1:0]  aop;
  int          tests = 0;
  int          fails = 0;
  bit          done  = 0;

  always #5 clk = ~clk;

  main_ctrl_decoder u_main_ctrl_decoder (
    .instr_i     (instr),
    .br_o        (br),
    .jp_o        (jp),
    .rwe_o       (rwe),
    .dmwe_o      (dmwe),
    .rwd_o       (rwd),
    .rdst_o      (rdst),
    .alu_b_imm_o (bimm),
    .alu_op_o    (aop)
  );

  // Output word packs {br,jp,rwe,dmwe,rwd,rdst,bimm,aop[1:0]}.
  localparam logic [8:0] E_ADD   = 9'b0_0_1_0_0_1_0_00;
  localparam logic [8:0] E_ADDI  = 9'b0_0_1_0_0_0_1_00;
  localparam logic [8:0] E_LOAD  = 9'b0_0_1_0_1_0_1_00;
  localparam logic [8:0] E_STORE = 9'b0_0_0_1_0_0_1_00;
  localparam logic [8:0] E_BEQ   = 9'b1_0_0_0_0_0_0_01;
  localparam logic [8:0] E_JUMP  = 9'b0_1_0_0_0_0_0_00;
  localparam logic [8:0] E_NONE  = 9'b0;

  // Reference model: a lookup by opcode number, written as integers.
  function automatic logic [8:0] model(logic [31:0] w);
    int op, fn;
    op = int'(w >> 26);
    fn = int'(w % 64);
    if (op == 0)  return (fn == 32) ? E_ADD : E_NONE;
    if (op == 8)  return E_ADDI;
    if (op == 35) return E_LOAD;
    if (op == 43) return E_STORE;
    if (op == 4)  return E_BEQ;
    if (op == 2)  return E_JUMP;
    return E_NONE;
  endfunction

  function automatic string tag_of(logic [31:0] w);
    int op;
    op = int'(w >> 26);
    case (op)
      0:  return (w[5:0] == 6'h20) ? "R1" : "R8";
      8:  return "R2";
      35: return "R3";
      43: return "R4";
      4:  return "R5";
      2:  return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input logic [31:0] w, input logic [8:0] exp, input string req);
    logic [8:0] act;
    @(posedge clk);
    instr = w;
    @(negedge clk);
    act = {br, jp, rwe, dmwe, rwd, rdst, bimm, aop};
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s instr=%08h actual=%09b expected=%09b", req, w, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(int op, logic [25:0] rest);
    return {6'(op), rest};
  endfunction

  initial begin
    int fn_list[6] = '{'h00, 'h21, 'h22, 'h24, 'h28, 'h30};
    int ops[6]     = '{'h00, 'h08, 'h23, 'h2B, 'h04, 'h02};
    // Quiet state for an all-zero word (R-type, funct 0): R8
    check(32'h0000_0000, E_NONE, "R8");
    // Directed patterns per instruction
    check(32'h0043_0820, E_ADD,   "R1");
    check(32'h2041_0005, E_ADDI,  "R2");
    check(32'h8C62_0004, E_LOAD,  "R3");
    check(32'hAC62_0004, E_STORE, "R4 R10");
    check(32'h1022_FFFE, E_BEQ,   "R5 R10");
    check(32'h0800_0100, E_JUMP,  "R6 R10");
    check(32'h3C00_0000, E_NONE,  "R7");
    check(32'hFC00_0000, E_NONE,  "R7");
    // R-type near misses on the function code: R8
    foreach (fn_list[i]) check(mk(0, 26'(fn_list[i])), E_NONE, "R8");
    // Middle and low fields do not steer the decode: R9
    foreach (ops[i]) begin
      logic [31:0] base;
      base = mk(ops[i], 26'h3FF_FFC0 | 26'h20);
      check(base, model(base), "R9");
      if (ops[i] != 0) begin
        check(mk(ops[i], 26'h22), model(mk(ops[i], 26'h0)), "R9");
        check(mk(ops[i], 26'h3FF_FFFF), model(mk(ops[i], 26'h0)), "R9");
      end
    end
    // Sweep every opcode with random payloads against the model
    for (int op = 0; op < 64; op++) begin
      for (int k = 0; k < 8; k++) begin
        logic [31:0] w;
        w = mk(op, 26'($urandom));
        if (k == 0 && op == 0) w[5:0] = 6'h20;
        check(w, model(w), tag_of(w));
      end
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule